// File: doc/BRIEF.md
# Dataflow Operand Join Unit

This block gathers the input operands of multi-input dataflow nodes and announces each node once all of its operands have arrived. Eight frame slots each hold the state of one pending node. A slot is armed by an init command that gives it a mode, a reload value and the address of the thread to start. Each slot also has room for up to four 32-bit operands.

In mask mode the reload value is a presence mask with one bit per operand position. A token names a slot, a position and a data word. The unit stores the word and clears that position's bit. When the mask becomes empty, the unit emits a fire event that carries the slot, the thread address and the whole operand vector. In counter mode the reload value is a count. Each post message to the slot lowers the count by one, and the slot fires when the count reaches zero.

After a slot fires it goes idle until the next init command arms it again. The unit does not compute the node and does not schedule the thread; it only reports that the thread is ready to run.

Top module: `join_unit`

## Requirements
- R1: After reset, fire_valid and dup_flag are 0 and every slot is inactive, so no token or post to any slot produces an output.
- R2: An init command arms slot init_slot with the thread address init_thread. With init_mode 0 (mask mode) the pending mask is the low 4 bits of init_value, and bit p stands for operand position p. With init_mode 1 (counter mode) the pending count is init_value. A zero mask or zero count leaves the slot inactive.
- R3: A token to an active mask-mode slot whose bit tok_pos is still set stores tok_data at that position and clears the bit. If other bits are still set, the unit produces no output.
- R4: When a token clears the last pending bit, the unit emits a fire event. fire_valid pulses for one cycle and carries fire_slot, fire_thread and fire_ops, with operand p in bits [32p+31:32p]. Positions whose bit was not set in the init mask read as zero.
- R5: A token whose position bit is already clear in an active mask-mode slot is a duplicate. The unit pulses dup_flag, leaves the stored data and the mask unchanged, and does not fire.
- R6: In counter mode each post lowers the count by one. When the count reaches zero the slot fires with fire_ops all zero.
- R7: A slot that has fired is inactive. Tokens and posts to it are ignored until the next init command.
- R8: Tokens to a counter-mode slot and posts to a mask-mode slot are ignored and leave the slot's state unchanged.
- R9: In any one cycle only one command is taken. Init has the highest priority, then token, then post, and the lower-priority commands of that cycle are dropped.
- R10: All outputs are registered. A fire or duplicate event appears in the cycle after the clock edge that accepted the command. fire_slot, fire_thread and fire_ops hold their values until the next fire event.
- R11: Slots are independent. Commands to one slot never change the state of another slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_valid | input | 1 | Init command strobe |
| init_slot | input | 3 | Slot to arm |
| init_mode | input | 1 | 0 mask mode, 1 counter mode |
| init_value | input | 8 | Mask (low 4 bits) or count |
| init_thread | input | 16 | Thread address reported on fire |
| tok_valid | input | 1 | Operand token strobe |
| tok_slot | input | 3 | Target slot of the token |
| tok_pos | input | 2 | Operand position |
| tok_data | input | 32 | Operand value |
| post_valid | input | 1 | Counter post strobe |
| post_slot | input | 3 | Target slot of the post |
| fire_valid | output | 1 | One-cycle fire pulse |
| fire_slot | output | 3 | Slot that fired |
| fire_thread | output | 16 | Thread address of the fired slot |
| fire_ops | output | 128 | Operand vector, position p at [32p+31:32p] |
| dup_flag | output | 1 | One-cycle pulse on a duplicate token |

## Verification
The bench arms every slot with every nonzero mask and sends the tokens in both ascending and descending position order. A design that compared the wrong bit, fired early, or forgot to bypass the final operand would return a stale or missing word. Repeated positions probe the duplicate path: a faulty unit would overwrite the first operand or fire on a repeat. Counters of length one to six on every slot, zero reload values, and post/token traffic sent to the wrong mode expose off-by-one countdowns and modes that leak into each other. Same-cycle init, token and post commands, and tokens sent to an already-fired slot, catch a wrong priority order and slots that fail to go idle.

// File: rtl/join_pkg.sv
package join_pkg;
  typedef enum logic {
    MODE_MASK  = 1'b0,
    MODE_COUNT = 1'b1
  } join_mode_e;
endpackage

// File: rtl/join_slot_table.sv
module join_slot_table
  import join_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_POS   = 4,
  parameter int CNT_W     = 8,
  parameter int TADDR_W   = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  join_mode_e         wr_mode,
  input  logic               wr_act,
  input  logic [CNT_W-1:0]   wr_pend,
  input  logic [NUM_POS-1:0] wr_need,
  input  logic [TADDR_W-1:0] wr_thr,
  input  logic [SLOT_W-1:0]  rd_slot,
  output join_mode_e         rd_mode,
  output logic               rd_act,
  output logic [CNT_W-1:0]   rd_pend,
  output logic [NUM_POS-1:0] rd_need,
  output logic [TADDR_W-1:0] rd_thr
);
  join_mode_e         mode_q [NUM_SLOTS];
  logic               act_q  [NUM_SLOTS];
  logic [CNT_W-1:0]   pend_q [NUM_SLOTS];
  logic [NUM_POS-1:0] need_q [NUM_SLOTS];
  logic [TADDR_W-1:0] thr_q  [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[s] <= MODE_MASK;
        act_q[s]  <= 1'b0;
        pend_q[s] <= '0;
        need_q[s] <= '0;
        thr_q[s]  <= '0;
      end else if (wr_en && wr_slot == SLOT_W'(s)) begin
        mode_q[s] <= wr_mode;
        act_q[s]  <= wr_act;
        pend_q[s] <= wr_pend;
        need_q[s] <= wr_need;
        thr_q[s]  <= wr_thr;
      end
    end
  end

  assign rd_mode = mode_q[rd_slot];
  assign rd_act  = act_q[rd_slot];
  assign rd_pend = pend_q[rd_slot];
  assign rd_need = need_q[rd_slot];
  assign rd_thr  = thr_q[rd_slot];
endmodule

// File: rtl/join_operand_store.sv
module join_operand_store #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_POS   = 4,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int POS_W    = $clog2(NUM_POS)
) (
  input  logic                            clk,
  input  logic                            we,
  input  logic [SLOT_W-1:0]               wr_slot,
  input  logic [POS_W-1:0]                wr_pos,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [SLOT_W-1:0]               rd_slot,
  output logic [NUM_POS-1:0][DATA_W-1:0]  rd_ops
);
  // One memory bank per operand position; each bank is slot-addressed.
  for (genvar p = 0; p < NUM_POS; p++) begin : g_bank
    logic [DATA_W-1:0] mem [NUM_SLOTS];
    always_ff @(posedge clk) begin
      if (we && wr_pos == POS_W'(p)) mem[wr_slot] <= wr_data;
    end
    assign rd_ops[p] = mem[rd_slot];
  end
endmodule

// File: rtl/join_ctrl.sv
module join_ctrl
  import join_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_POS   = 4,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int TADDR_W   = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int POS_W    = $clog2(NUM_POS)
) (
  input  logic                           init_valid,
  input  logic [SLOT_W-1:0]              init_slot,
  input  logic                           init_mode,
  input  logic [CNT_W-1:0]               init_value,
  input  logic [TADDR_W-1:0]             init_thread,
  input  logic                           tok_valid,
  input  logic [SLOT_W-1:0]              tok_slot,
  input  logic [POS_W-1:0]               tok_pos,
  input  logic [DATA_W-1:0]              tok_data,
  input  logic                           post_valid,
  input  logic [SLOT_W-1:0]              post_slot,
  output logic [SLOT_W-1:0]              sel_slot,
  input  join_mode_e                     rd_mode,
  input  logic                           rd_act,
  input  logic [CNT_W-1:0]               rd_pend,
  input  logic [NUM_POS-1:0]             rd_need,
  input  logic [TADDR_W-1:0]             rd_thr,
  input  logic [NUM_POS-1:0][DATA_W-1:0] rd_ops,
  output logic                           wr_en,
  output join_mode_e                     wr_mode,
  output logic                           wr_act,
  output logic [CNT_W-1:0]               wr_pend,
  output logic [NUM_POS-1:0]             wr_need,
  output logic [TADDR_W-1:0]             wr_thr,
  output logic                           op_we,
  output logic                           fire_now,
  output logic                           dup_now,
  output logic [NUM_POS-1:0][DATA_W-1:0] fire_ops_nxt
);
  logic [CNT_W-1:0] clr_bit;
  logic [CNT_W-1:0] next_mask;
  logic [CNT_W-1:0] next_cnt;
  logic             use_tok;

  assign clr_bit   = CNT_W'(1) << tok_pos;
  assign next_mask = rd_pend & ~clr_bit;
  assign next_cnt  = rd_pend - CNT_W'(1);
  assign use_tok   = !init_valid && tok_valid;

  always_comb begin
    if (init_valid)     sel_slot = init_slot;
    else if (tok_valid) sel_slot = tok_slot;
    else                sel_slot = post_slot;
  end

  always_comb begin
    wr_en    = 1'b0;
    wr_mode  = rd_mode;
    wr_act   = rd_act;
    wr_pend  = rd_pend;
    wr_need  = rd_need;
    wr_thr   = rd_thr;
    op_we    = 1'b0;
    fire_now = 1'b0;
    dup_now  = 1'b0;
    if (init_valid) begin
      wr_en  = 1'b1;
      wr_thr = init_thread;
      if (init_mode) begin
        wr_mode = MODE_COUNT;
        wr_need = '0;
        wr_pend = init_value;
      end else begin
        wr_mode = MODE_MASK;
        wr_need = init_value[NUM_POS-1:0];
        wr_pend = CNT_W'(init_value[NUM_POS-1:0]);
      end
      wr_act = (wr_pend != '0);
    end else if (tok_valid) begin
      if (rd_act && rd_mode == MODE_MASK) begin
        if ((rd_pend & clr_bit) == '0) begin
          dup_now = 1'b1;
        end else begin
          op_we    = 1'b1;
          wr_en    = 1'b1;
          wr_pend  = next_mask;
          wr_act   = (next_mask != '0);
          fire_now = (next_mask == '0);
        end
      end
    end else if (post_valid) begin
      if (rd_act && rd_mode == MODE_COUNT) begin
        wr_en    = 1'b1;
        wr_pend  = next_cnt;
        wr_act   = (next_cnt != '0);
        fire_now = (next_cnt == '0);
      end
    end
  end

  // Operand vector for a fire: bypass the word arriving this cycle.
  always_comb begin
    for (int p = 0; p < NUM_POS; p++) begin
      if (rd_mode == MODE_COUNT || !rd_need[p])
        fire_ops_nxt[p] = '0;
      else if (use_tok && tok_pos == POS_W'(p))
        fire_ops_nxt[p] = tok_data;
      else
        fire_ops_nxt[p] = rd_ops[p];
    end
  end
endmodule

// File: rtl/join_unit.sv
module join_unit
  import join_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_POS   = 4,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int TADDR_W   = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int POS_W    = $clog2(NUM_POS),
  localparam int OPS_W    = NUM_POS * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_valid,
  input  logic [SLOT_W-1:0]  init_slot,
  input  logic               init_mode,
  input  logic [CNT_W-1:0]   init_value,
  input  logic [TADDR_W-1:0] init_thread,
  input  logic               tok_valid,
  input  logic [SLOT_W-1:0]  tok_slot,
  input  logic [POS_W-1:0]   tok_pos,
  input  logic [DATA_W-1:0]  tok_data,
  input  logic               post_valid,
  input  logic [SLOT_W-1:0]  post_slot,
  output logic               fire_valid,
  output logic [SLOT_W-1:0]  fire_slot,
  output logic [TADDR_W-1:0] fire_thread,
  output logic [OPS_W-1:0]   fire_ops,
  output logic               dup_flag
);
  logic [SLOT_W-1:0]              sel_slot;
  join_mode_e                     rd_mode, wr_mode;
  logic                           rd_act, wr_act, wr_en;
  logic [CNT_W-1:0]               rd_pend, wr_pend;
  logic [NUM_POS-1:0]             rd_need, wr_need;
  logic [TADDR_W-1:0]             rd_thr, wr_thr;
  logic [NUM_POS-1:0][DATA_W-1:0] rd_ops, fire_ops_nxt;
  logic                           op_we, fire_now, dup_now;

  join_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_POS(NUM_POS), .CNT_W(CNT_W), .TADDR_W(TADDR_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_slot(sel_slot), .wr_mode(wr_mode), .wr_act(wr_act),
    .wr_pend(wr_pend), .wr_need(wr_need), .wr_thr(wr_thr),
    .rd_slot(sel_slot), .rd_mode(rd_mode), .rd_act(rd_act),
    .rd_pend(rd_pend), .rd_need(rd_need), .rd_thr(rd_thr)
  );

  join_operand_store #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_POS(NUM_POS), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .we(op_we), .wr_slot(tok_slot), .wr_pos(tok_pos),
    .wr_data(tok_data), .rd_slot(sel_slot), .rd_ops(rd_ops)
  );

  join_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_POS(NUM_POS), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .TADDR_W(TADDR_W)
  ) u_ctrl (
    .init_valid(init_valid), .init_slot(init_slot), .init_mode(init_mode),
    .init_value(init_value), .init_thread(init_thread),
    .tok_valid(tok_valid), .tok_slot(tok_slot), .tok_pos(tok_pos),
    .tok_data(tok_data), .post_valid(post_valid), .post_slot(post_slot),
    .sel_slot(sel_slot), .rd_mode(rd_mode), .rd_act(rd_act),
    .rd_pend(rd_pend), .rd_need(rd_need), .rd_thr(rd_thr), .rd_ops(rd_ops),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_act(wr_act), .wr_pend(wr_pend),
    .wr_need(wr_need), .wr_thr(wr_thr), .op_we(op_we),
    .fire_now(fire_now), .dup_now(dup_now), .fire_ops_nxt(fire_ops_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_valid  <= 1'b0;
      dup_flag    <= 1'b0;
      fire_slot   <= '0;
      fire_thread <= '0;
      fire_ops    <= '0;
    end else begin
      fire_valid <= fire_now;
      dup_flag   <= dup_now;
      if (fire_now) begin
        fire_slot   <= sel_slot;
        fire_thread <= rd_thr;
        fire_ops    <= fire_ops_nxt;
      end
    end
  end
endmodule

// File: rtl/join_unit_chk.sv
module join_unit_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_POS   = 4,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int TADDR_W   = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int POS_W    = $clog2(NUM_POS),
  localparam int OPS_W    = NUM_POS * DATA_W
) (
  input logic               clk,
  input logic               rst,
  input logic               init_valid,
  input logic [SLOT_W-1:0]  init_slot,
  input logic               init_mode,
  input logic [CNT_W-1:0]   init_value,
  input logic [TADDR_W-1:0] init_thread,
  input logic               tok_valid,
  input logic [SLOT_W-1:0]  tok_slot,
  input logic [POS_W-1:0]   tok_pos,
  input logic [DATA_W-1:0]  tok_data,
  input logic               post_valid,
  input logic [SLOT_W-1:0]  post_slot,
  input logic               fire_valid,
  input logic [SLOT_W-1:0]  fire_slot,
  input logic [TADDR_W-1:0] fire_thread,
  input logic [OPS_W-1:0]   fire_ops,
  input logic               dup_flag
);
  // R1: the cycle after reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fire_valid && !dup_flag));

  // R9: a fire needs an accepted token or post, never an init
  p_fire_cause_r9: assert property (@(posedge clk) disable iff (rst)
    fire_valid |-> $past(!init_valid && (tok_valid || post_valid)));

  // R5: a duplicate is flagged only for an accepted token and never fires
  p_dup_cause_r5: assert property (@(posedge clk) disable iff (rst)
    dup_flag |-> ($past(tok_valid && !init_valid) && !fire_valid));

  // R4: a token-driven fire names the token's slot
  p_fire_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (fire_valid && $past(tok_valid && !init_valid)) |-> fire_slot == $past(tok_slot));

  // R6: a post-driven fire carries an all-zero operand vector
  p_count_zero_ops_r6: assert property (@(posedge clk) disable iff (rst)
    (fire_valid && $past(post_valid && !tok_valid && !init_valid)) |-> fire_ops == '0);

  // R10: fire payload holds between fire events
  p_payload_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!fire_valid && !$past(rst)) |-> ($stable(fire_slot) && $stable(fire_thread) && $stable(fire_ops)));
endmodule

bind join_unit join_unit_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_POS(NUM_POS), .DATA_W(DATA_W),
  .CNT_W(CNT_W), .TADDR_W(TADDR_W)
) u_chk (.*);

// File: tb/sim_join_unit.sv
`timescale 1ns/1ps
module sim_join_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         init_valid = 0, init_mode = 0, tok_valid = 0, post_valid = 0;
  logic [2:0]   init_slot = 0, tok_slot = 0, post_slot = 0;
  logic [7:0]   init_value = 0;
  logic [15:0]  init_thread = 0;
  logic [1:0]   tok_pos = 0;
  logic [31:0]  tok_data = 0;
  logic         fire_valid, dup_flag;
  logic [2:0]   fire_slot;
  logic [15:0]  fire_thread;
  logic [127:0] fire_ops;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  join_unit u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] opval(int s, int p, int m);
    return 32'hA000_0000 + 32'(s) * 32'h0001_0000 + 32'(p) * 32'h100 + 32'(m);
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
    init_valid = 0; tok_valid = 0; post_valid = 0;
  endtask

  task automatic do_init(int s, bit md, int v, int thr);
    init_valid = 1; init_slot = 3'(s); init_mode = md;
    init_value = 8'(v); init_thread = 16'(thr);
  endtask
  task automatic do_tok(int s, int p, logic [31:0] d);
    tok_valid = 1; tok_slot = 3'(s); tok_pos = 2'(p); tok_data = d;
  endtask
  task automatic do_post(int s);
    post_valid = 1; post_slot = 3'(s);
  endtask

  task automatic chk_none(string tag);
    n_chk++;
    if (fire_valid !== 1'b0 || dup_flag !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: fire=%b dup=%b expected fire=0 dup=0", tag, fire_valid, dup_flag);
    end
  endtask
  task automatic chk_dup(string tag);
    n_chk++;
    if (fire_valid !== 1'b0 || dup_flag !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: fire=%b dup=%b expected fire=0 dup=1", tag, fire_valid, dup_flag);
    end
  endtask
  task automatic chk_fire(string tag, int s, int thr, logic [127:0] ops);
    n_chk++;
    if (fire_valid !== 1'b1 || dup_flag !== 1'b0 || fire_slot !== 3'(s) ||
        fire_thread !== 16'(thr) || fire_ops !== ops) begin
      n_fail++;
      $display("FAIL %s: fire=%b slot=%0d thr=%h ops=%h expected fire=1 slot=%0d thr=%h ops=%h",
               tag, fire_valid, fire_slot, fire_thread, fire_ops, s, 16'(thr), ops);
    end
  endtask

  initial begin
    logic [127:0] exp_ops;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state and inactive slots
    chk_none("R1 reset");
    for (int s = 0; s < 8; s++) begin
      do_tok(s, 0, 32'h1); step(); chk_none("R1 token to unarmed slot");
      do_post(s); step(); chk_none("R1 post to unarmed slot");
    end

    // R2/R3/R4: every slot, every nonzero mask, two arrival orders
    for (int s = 0; s < 8; s++) begin
      for (int m = 1; m < 16; m++) begin
        int rem, thr;
        rem = m; thr = s * 256 + m;
        do_init(s, 0, m, thr); step(); chk_none("R2 init");
        exp_ops = '0;
        for (int k = 0; k < 4; k++) begin
          int p;
          p = (m % 2 == 1) ? 3 - k : k;
          if (m[p]) begin
            exp_ops[32*p +: 32] = opval(s, p, m);
            do_tok(s, p, opval(s, p, m)); step();
            rem = rem & ~(1 << p);
            if (rem != 0) chk_none("R3 partial arrival");
            else begin
              chk_fire("R4 mask fire", s, thr, exp_ops);
              step(); // idle cycle
              n_chk++;
              if (fire_valid !== 1'b0 || fire_slot !== 3'(s)) begin
                n_fail++;
                $display("FAIL R10: fire=%b slot=%0d expected fire=0 slot=%0d",
                         fire_valid, fire_slot, s);
              end
            end
          end
        end
        // R7: fired slot is inactive
        do_tok(s, 0, 32'hDEAD); step(); chk_none("R7 token after fire");
      end
    end

    // R5: duplicate arrival keeps first data
    do_init(3, 0, 5, 16'h0303); step(); chk_none("R2 init");
    do_tok(3, 0, 32'h1111_1111); step(); chk_none("R3 first");
    do_tok(3, 0, 32'h2222_2222); step(); chk_dup("R5 duplicate");
    do_tok(3, 2, 32'h3333_3333); step();
    exp_ops = '0; exp_ops[31:0] = 32'h1111_1111; exp_ops[95:64] = 32'h3333_3333;
    chk_fire("R5 fire keeps first operand", 3, 16'h0303, exp_ops);

    // R6: counter mode, counts 1..6 on every slot
    for (int s = 0; s < 8; s++) begin
      for (int n = 1; n <= 6; n++) begin
        do_init(s, 1, n, 16'h8000 + s * 16 + n); step(); chk_none("R2 count init");
        for (int i = 1; i <= n; i++) begin
          do_post(s); step();
          if (i < n) chk_none("R6 partial count");
          else chk_fire("R6 count fire", s, 16'h8000 + s * 16 + n, '0);
        end
        do_post(s); step(); chk_none("R7 post after fire");
      end
    end

    // R2: zero reload leaves the slot inactive
    do_init(2, 0, 0, 1); step(); do_tok(2, 0, 32'h5); step(); chk_none("R2 zero mask");
    do_init(2, 1, 0, 1); step(); do_post(2); step(); chk_none("R2 zero count");
    // R2: only low 4 mask bits used
    do_init(2, 0, 8'hF1, 16'h0222); step();
    do_tok(2, 0, 32'h77); step();
    exp_ops = '0; exp_ops[31:0] = 32'h77;
    chk_fire("R2 mask uses low bits", 2, 16'h0222, exp_ops);

    // R8: mode isolation
    do_init(4, 1, 2, 16'h0444); step();
    do_tok(4, 0, 32'h9); step(); chk_none("R8 token to counter slot");
    do_post(4); step(); chk_none("R8 count not disturbed");
    do_post(4); step(); chk_fire("R8 count completes", 4, 16'h0444, '0);
    do_init(5, 0, 1, 16'h0555); step();
    do_post(5); step(); chk_none("R8 post to mask slot");
    do_tok(5, 0, 32'hAB); step();
    exp_ops = '0; exp_ops[31:0] = 32'hAB;
    chk_fire("R8 mask completes", 5, 16'h0555, exp_ops);

    // R9: init beats token, token beats post
    do_init(1, 0, 1, 16'h0111); step();
    do_init(6, 1, 1, 16'h0666); do_tok(1, 0, 32'hC1); step(); chk_none("R9 token dropped under init");
    do_tok(1, 0, 32'hC2); do_post(6); step();
    exp_ops = '0; exp_ops[31:0] = 32'hC2;
    chk_fire("R9 token wins over post", 1, 16'h0111, exp_ops);
    do_post(6); step(); chk_fire("R9 dropped post left count", 6, 16'h0666, '0);

    // R11: interleaved slots stay independent
    do_init(6, 0, 3, 16'h0606); step();
    do_init(7, 0, 3, 16'h0707); step();
    do_tok(6, 0, 32'h60); step(); chk_none("R11 a");
    do_tok(7, 1, 32'h71); step(); chk_none("R11 b");
    do_tok(7, 0, 32'h70); step();
    exp_ops = '0; exp_ops[31:0] = 32'h70; exp_ops[63:32] = 32'h71;
    chk_fire("R11 slot 7", 7, 16'h0707, exp_ops);
    do_tok(6, 1, 32'h61); step();
    exp_ops = '0; exp_ops[31:0] = 32'h60; exp_ops[63:32] = 32'h61;
    chk_fire("R11 slot 6", 6, 16'h0606, exp_ops);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule